// File: doc/BRIEF.md
# Ethernet CRC-32 frame check unit

This block computes the 32-bit frame check sequence used on Ethernet links, one byte per clock. It has one datapath and two modes. In generate mode a frame is streamed in byte by byte; once the last byte is taken, the block presents the four check bytes to append, one per clock, on its own output. In check mode a received frame is streamed in together with its trailing four check bytes. The block then reports whether the frame arrived intact.

Each byte is folded into the register least significant bit first, so the register holds the bit-reflected form of the remainder. Start of frame presets the register to all ones, which complements the first 32 bits of the frame. In generate mode the register is inverted to give the check value, and its lowest byte is sent first. In check mode the check bytes are not stripped. The frame is judged good when the register lands on a fixed residue. No comparison against a stored value is made.

Top module: `fcs32_engine`

## Requirements
- R1: While reset (synchronous, active high) is applied and on the first cycle after it, `fcs_out_vld`, `frm_done` and `frm_good` are 0.
- R2: Bytes are folded in least significant bit first with the reflected polynomial 0xEDB88320. The register is preset to all ones when `frm_start` is accepted. For the nine bytes 0x31..0x39 the four check bytes are 0x26, 0x39, 0xF4, 0xCB (value 0xCBF43926).
- R3: In generate mode (`chk_mode`=0) an accepted `frm_end` makes the outputs change on the next cycle. From then on `fcs_out` carries the inverted register, byte 0 (bits 7:0) first and byte 3 last, with `fcs_out_vld` high. `fcs_out` is 0 whenever `fcs_out_vld` is low.
- R4: A frame with no data bytes gives four check bytes of 0x00. Such a frame is `frm_start` and `frm_end` in the same cycle with `byte_vld` low.
- R5: While check bytes are being sent, `frm_start`, `byte_vld`, `frm_end` and `chk_mode` are ignored. They alter neither the bytes in flight nor `frm_done`/`frm_good`, and they do not start a new frame.
- R6: Every burst of `fcs_out_vld` lasts exactly four cycles.
- R7: In check mode (`chk_mode`=1) `frm_done` is 1 on the cycle after an accepted `frm_end`. `frm_good` is then 1 exactly when the register, after data and received check bytes, equals 0xDEBB20E3.
- R8: `frm_done` and `frm_good` hold their values until the next accepted `frm_start`, and both are 0 on the cycle after it.
- R9: A check-mode frame never raises `fcs_out_vld`.
- R10: A cycle with `byte_vld` low adds nothing to the register, so idle gaps inside a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chk_mode | input | 1 | 1 = check a received frame, 0 = generate check bytes; sampled with `frm_end` |
| frm_start | input | 1 | Presets the register; qualifies the first byte if `byte_vld` is high |
| byte_vld | input | 1 | `byte_in` carries a frame byte this cycle |
| byte_in | input | 8 | Frame byte |
| frm_end | input | 1 | Last cycle of the frame (the byte on it, if valid, is included) |
| fcs_out | output | 8 | Check byte to append, lowest byte first |
| fcs_out_vld | output | 1 | `fcs_out` is valid (four cycles per generated frame) |
| frm_done | output | 1 | Check-mode status valid, held until the next frame start |
| frm_good | output | 1 | Received frame intact (meaningful while `frm_done` is 1) |

## Verification
The bench builds the block with its default parameters: 32-bit register, 8-bit byte lanes, the reflected Ethernet polynomial, an all-ones preset and the standard residue. With these values the common nine-character check string and the receive residue are directly usable as fixed expected numbers, next to a bit-serial reference model in the bench. Those values cover generate and check frames of zero, one, nine and 64 bytes, with and without idle gaps, and also frames with a corrupted byte. Junk strobes and a mode flip are driven during check-byte output to show that they have no effect.

// File: rtl/fcs32_pkg.sv
package fcs32_pkg;

    localparam int CRC_W     = 32;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = CRC_W / LANE_W;
    localparam int LEFT_W    = $clog2(NUM_LANES + 1);
    localparam int IDX_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    localparam logic [CRC_W-1:0] POLY_REFL_DEF = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] PRESET_DEF    = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] RESIDUE_DEF   = 32'hDEBB_20E3;

    typedef struct packed {
        logic [CRC_W-1:0]  crc;   // running reflected remainder
        logic [CRC_W-1:0]  fcs;   // inverted remainder being sent
        logic [LEFT_W-1:0] left;  // check bytes still to send
        logic              good;  // check-mode verdict
        logic              done;  // check-mode verdict valid
    } fcs32_state_t;

endpackage

// File: rtl/fcs32_byte_step.sv
module fcs32_byte_step #(
    parameter int                 CRC_W  = 32,
    parameter int                 LANE_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 32'hEDB8_8320
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [LANE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);

    // Unrolled LSB-first division: one shift-and-conditional-xor per bit.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = 0; b < LANE_W; b++) begin
            fb = c[0] ^ byte_in[b];
            c  = c >> 1;
            if (fb) begin
                c = c ^ POLY;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/fcs32_lane_pick.sv
module fcs32_lane_pick #(
    parameter int CRC_W  = 32,
    parameter int LANE_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [CRC_W-1:0]  word_in,
    input  logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] lane_out
);

    localparam int NUM_LANES = CRC_W / LANE_W;

    logic [LANE_W-1:0] lanes [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lanes[g] = word_in[g*LANE_W +: LANE_W];
    end

    assign lane_out = lanes[idx];

endmodule

// File: rtl/fcs32_engine.sv
module fcs32_engine
    import fcs32_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY    = POLY_REFL_DEF,
    parameter logic [CRC_W-1:0] PRESET  = PRESET_DEF,
    parameter logic [CRC_W-1:0] RESIDUE = RESIDUE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_mode,
    input  logic              frm_start,
    input  logic              byte_vld,
    input  logic [LANE_W-1:0] byte_in,
    input  logic              frm_end,
    output logic [LANE_W-1:0] fcs_out,
    output logic              fcs_out_vld,
    output logic              frm_done,
    output logic              frm_good
);

    localparam logic [LEFT_W-1:0] LANES_C = LEFT_W'(NUM_LANES);

    fcs32_state_t st_q, st_d;

    logic              busy;
    logic              take_start, take_byte, take_end;
    logic [CRC_W-1:0]  crc_base, crc_stepped, crc_now;
    logic [IDX_W-1:0]  lane_idx;
    logic [LANE_W-1:0] lane_byte;

    fcs32_byte_step #(
        .CRC_W  (CRC_W),
        .LANE_W (LANE_W),
        .POLY   (POLY)
    ) u_step (
        .crc_in  (crc_base),
        .byte_in (byte_in),
        .crc_out (crc_stepped)
    );

    fcs32_lane_pick #(
        .CRC_W  (CRC_W),
        .LANE_W (LANE_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .word_in  (st_q.fcs),
        .idx      (lane_idx),
        .lane_out (lane_byte)
    );

    always_comb begin
        busy       = (st_q.left != '0);
        take_start = frm_start & ~busy;
        take_byte  = byte_vld  & ~busy;
        take_end   = frm_end   & ~busy;

        crc_base = take_start ? PRESET : st_q.crc;
        crc_now  = take_byte ? crc_stepped : crc_base;
        lane_idx = IDX_W'(LANES_C - st_q.left);

        st_d     = st_q;
        st_d.crc = crc_now;

        if (busy) begin
            st_d.left = st_q.left - LEFT_W'(1);
        end

        if (take_start) begin
            st_d.done = 1'b0;
            st_d.good = 1'b0;
        end

        if (take_end) begin
            if (chk_mode) begin
                st_d.done = 1'b1;
                st_d.good = (crc_now == RESIDUE);
            end else begin
                st_d.fcs  = ~crc_now;
                st_d.left = LANES_C;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{crc: PRESET, fcs: '0, left: '0, good: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fcs_out_vld = busy;
    assign fcs_out     = busy ? lane_byte : '0;
    assign frm_done    = st_q.done;
    assign frm_good    = st_q.good;

endmodule

// File: rtl/fcs32_engine_chk.sv
module fcs32_engine_chk (
    input logic clk,
    input logic rst,
    input logic chk_mode,
    input logic frm_start,
    input logic frm_end,
    input logic fcs_out_vld,
    input logic frm_done,
    input logic frm_good
);

    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (fcs_out_vld) begin
            run_q <= run_q + 4'd1;
        end else begin
            run_q <= '0;
        end
    end

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!fcs_out_vld && !frm_done && !frm_good));

    // R3: generate-mode end starts emission next cycle
    a_r3_gen_starts: assert property (@(posedge clk) disable iff (rst)
        (frm_end && !chk_mode && !fcs_out_vld) |=> fcs_out_vld);

    // R5: strobes during emission leave the status untouched
    a_r5_status_frozen: assert property (@(posedge clk) disable iff (rst)
        fcs_out_vld |=> ($stable(frm_done) && $stable(frm_good)));

    // R6: never more than four valid cycles in a row
    a_r6_max_four: assert property (@(posedge clk) disable iff (rst)
        fcs_out_vld |-> (run_q < 4'd4));

    // R6: a burst that ends has lasted exactly four cycles
    a_r6_exact_four: assert property (@(posedge clk) disable iff (rst)
        (!fcs_out_vld && run_q != 4'd0) |-> (run_q == 4'd4));

    // R7: check-mode end raises the status next cycle
    a_r7_done_next: assert property (@(posedge clk) disable iff (rst)
        (frm_end && chk_mode && !fcs_out_vld) |=> frm_done);

    // R8: status held until a new frame start
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !frm_start) |=> (frm_done && $stable(frm_good)));

    // R8: accepted start without end clears status
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (frm_start && !frm_end && !fcs_out_vld) |=> (!frm_done && !frm_good));

    // R9: check-mode frames never emit
    a_r9_no_emit: assert property (@(posedge clk) disable iff (rst)
        (frm_end && chk_mode && !fcs_out_vld) |=> !fcs_out_vld);

endmodule

bind fcs32_engine fcs32_engine_chk u_chk (.*);

// File: tb/sim_fcs32_engine.sv
module sim_fcs32_engine;

    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chk_mode = 1'b0;
    logic       frm_start = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       frm_end = 1'b0;
    logic [7:0] fcs_out;
    logic       fcs_out_vld;
    logic       frm_done;
    logic       frm_good;

    int n_chk = 0;
    int n_bad = 0;
    int run_len = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PER/2) clk = ~clk;

    fcs32_engine u0 (
        .clk         (clk),
        .rst         (rst),
        .chk_mode    (chk_mode),
        .frm_start   (frm_start),
        .byte_vld    (byte_vld),
        .byte_in     (byte_in),
        .frm_end     (frm_end),
        .fcs_out     (fcs_out),
        .fcs_out_vld (fcs_out_vld),
        .frm_done    (frm_done),
        .frm_good    (frm_good)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Bit-serial reference: preset ones, LSB first, reflected polynomial.
    function automatic logic [31:0] ref_reg(input logic [7:0] d[$]);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        foreach (d[i]) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ d[i][b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c;
    endfunction

    task automatic push_fcs(input logic [31:0] v);
        for (int k = 0; k < 4; k++) exp_q.push_back(v[k*8 +: 8]);
    endtask

    task automatic set_idle();
        frm_start = 1'b0;
        byte_vld  = 1'b0;
        frm_end   = 1'b0;
        byte_in   = 8'h00;
    endtask

    // Monitor: pops expected check bytes, measures burst length (R3, R6, R9).
    always @(negedge clk) begin
        logic [7:0] e;
        if (!rst) begin
            if (fcs_out_vld) begin
                run_len++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected check byte", {24'h0, fcs_out}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(fcs_out == e, "R3 check byte", {24'h0, fcs_out}, {24'h0, e});
                end
            end else begin
                if (run_len != 0)
                    check(run_len == 4, "R6 valid burst length", run_len, 4);
                if (fcs_out != 8'h00)
                    check(1'b0, "R3 idle output not zero", {24'h0, fcs_out}, 32'h0);
                run_len = 0;
            end
        end
    end

    // Drives one frame; gap>0 inserts an idle cycle before every gap-th byte.
    task automatic drive_frame(input logic [7:0] d[$], input bit mode,
                               input int gap, input bit junk);
        if (d.size() == 0) begin
            @(negedge clk);
            chk_mode = mode; frm_start = 1'b1; frm_end = 1'b1; byte_vld = 1'b0;
        end else begin
            for (int i = 0; i < d.size(); i++) begin
                if (gap > 0 && i > 0 && (i % gap) == 0) begin
                    @(negedge clk);
                    set_idle();
                end
                @(negedge clk);
                chk_mode  = mode;
                frm_start = (i == 0);
                frm_end   = (i == d.size() - 1);
                byte_vld  = 1'b1;
                byte_in   = d[i];
            end
        end
        if (!mode) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (junk) begin
                    frm_start = 1'b1; byte_vld = 1'b1; frm_end = 1'b1;
                    byte_in = 8'hA5; chk_mode = 1'b1;
                end else begin
                    set_idle();
                end
            end
            @(negedge clk);
            set_idle();
            chk_mode = 1'b0;
            check(exp_q.size() == 0, "R3 all four check bytes sent", exp_q.size(), 0);
            check(!fcs_out_vld, "R6 valid dropped after four", fcs_out_vld, 0);
        end else begin
            @(negedge clk);
            set_idle();
        end
    endtask

    task automatic check_frame(input logic [7:0] d[$], input bit exp_good, input string tag);
        drive_frame(d, 1'b1, 0, 1'b0);
        check(frm_done == 1'b1, {tag, " R7 done after end"}, frm_done, 1);
        check(frm_good == exp_good, {tag, " R7 verdict"}, frm_good, exp_good);
        repeat (3) @(negedge clk);
        check(frm_done == 1'b1 && frm_good == exp_good, {tag, " R8 status held"},
              {frm_done, frm_good}, {1'b1, exp_good});
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] s9[$];
        logic [7:0] big[$];
        logic [7:0] one[$];
        logic [7:0] none[$];
        logic [7:0] rx[$];
        logic [31:0] f;

        for (int i = 0; i < 9; i++) s9.push_back(8'h31 + 8'(i));
        for (int i = 0; i < 64; i++) big.push_back(8'(i * 7 + 3));
        one.push_back(8'h00);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!fcs_out_vld && !frm_done && !frm_good, "R1 reset outputs",
              {fcs_out_vld, frm_done, frm_good}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!fcs_out_vld && !frm_done && !frm_good, "R1 after reset",
              {fcs_out_vld, frm_done, frm_good}, 0);

        // R2: known check string, fixed expected bytes
        check(~ref_reg(s9) == 32'hCBF4_3926, "R2 reference value", ~ref_reg(s9), 32'hCBF4_3926);
        exp_q.push_back(8'h26); exp_q.push_back(8'h39);
        exp_q.push_back(8'hF4); exp_q.push_back(8'hCB);
        drive_frame(s9, 1'b0, 0, 1'b0);

        // R4: empty frame gives zero check bytes
        push_fcs(32'h0000_0000);
        drive_frame(none, 1'b0, 0, 1'b0);

        // R3: single byte frame
        push_fcs(~ref_reg(one));
        drive_frame(one, 1'b0, 0, 1'b0);

        // R10: long frame with idle gaps
        push_fcs(~ref_reg(big));
        drive_frame(big, 1'b0, 3, 1'b0);

        // R5: junk strobes during emission; status stays clear
        push_fcs(~ref_reg(s9));
        drive_frame(s9, 1'b0, 0, 1'b1);
        check(!frm_done && !frm_good, "R5 junk end ignored", {frm_done, frm_good}, 0);
        push_fcs(~ref_reg(big));
        drive_frame(big, 1'b0, 0, 1'b0);

        // R7: received frame with its check bytes is good
        rx = s9;
        rx.push_back(8'h26); rx.push_back(8'h39); rx.push_back(8'hF4); rx.push_back(8'hCB);
        check_frame(rx, 1'b1, "string");

        // R8: a start clears the status
        @(negedge clk);
        frm_start = 1'b1; byte_vld = 1'b1; byte_in = 8'h11;
        @(negedge clk);
        set_idle();
        check(!frm_done && !frm_good, "R8 cleared by start", {frm_done, frm_good}, 0);

        // R7: corrupted byte is bad
        rx[4] = rx[4] ^ 8'h10;
        check_frame(rx, 1'b0, "corrupt");

        // R7 and R10: long frame with gaps in check mode
        rx = big;
        f = ~ref_reg(big);
        for (int k = 0; k < 4; k++) rx.push_back(f[k*8 +: 8]);
        drive_frame(rx, 1'b1, 5, 1'b0);
        check(frm_done && frm_good, "R10 gapped check frame good", {frm_done, frm_good}, 3);

        // R7: empty frame in check mode is bad
        check_frame(none, 1'b0, "empty");

        // R9: no check bytes were left pending or emitted in check mode
        check(exp_q.size() == 0 && !fcs_out_vld, "R9 no emission in check mode",
              exp_q.size(), 0);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule